// File: doc/BRIEF.md
# Four-Phase Step Pattern Generator

This block is a Moore machine that walks a fixed ring of four 4-bit output patterns, one pattern per enabled clock edge. Its four output bits suit a row of four indicator lamps or the four coil phases of a stepper motor driver. There are no data inputs. A clock, a synchronous reset and an advance-enable are the only controls, so no stream handshake applies and every pin stays a plain level.

The machine state is a 2-bit binary phase code. Minimized combinational equations produce the following phase from the current one. A separate decoder derives the four outputs from the phase alone, so the output never depends on an input in the same cycle. The ring is 00, 01, 10, 11 and then back to 00. All four codes are in use, so no state is unreachable and no recovery path exists.

Top module: `step_pattern_gen`

## Requirements
- R1: A rising clock edge with `rst` high puts the machine in its home phase, so `{w,x,y,z}` reads 0001 after that edge. It keeps that value until the first edge with `rst` low and `adv_en` high.
- R2: With `rst` low and `adv_en` high, each rising edge moves `{w,x,y,z}` (w is the most significant bit) one step along the ring 0001 → 0011 → 1100 → 1000 → 0001.
- R3: Outside reset, `{w,x,y,z}` only ever shows one of the four ring patterns, and `z` is always the complement of `w`.
- R4: A rising edge with `rst` low and `adv_en` low leaves `{w,x,y,z}` unchanged.
- R5: The machine makes exactly one step per enabled edge. After k enabled edges since the last reset, the output is ring entry k mod 4, counting the entry 0001 as entry 0.
- R6: `rst` has priority over `adv_en`. An edge with both high gives 0001, not the next step.
- R7: The outputs change only just after a rising clock edge. Toggling `adv_en` between edges has no visible effect until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the home phase |
| adv_en | input | 1 | High: advance one phase per edge; low: hold |
| w | output | 1 | Pattern bit 3 |
| x | output | 1 | Pattern bit 2 |
| y | output | 1 | Pattern bit 1 |
| z | output | 1 | Pattern bit 0 |

## Verification
The ring is driven with long runs of `adv_en` high, which cover three full laps and separate a correct successor from a skipped or repeated step. Runs with `adv_en` low in the middle of the ring show whether the hold is truly inert, and a mixed run shows that held cycles do not count as steps. Reset is applied in a non-home phase with `adv_en` both low and high. This tells a real priority of `rst` apart from a reset that only works when idle. A toggle of `adv_en` between edges, with the outputs sampled twice in the same cycle, exposes any path from the input to the outputs that bypasses the register.

// File: rtl/step_pattern_pkg.sv
package step_pattern_pkg;
  localparam int PHASE_W = 2;
  localparam int PAT_W   = 4;

  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [PAT_W-1:0]   pattern_t;

  localparam phase_t PHASE_HOME = '0;
endpackage

// File: rtl/phase_next.sv
module phase_next
  import step_pattern_pkg::*;
(
  input  phase_t cur,
  output phase_t nxt
);
  // minimized successor equations: high bit toggles when low bit set
  always_comb begin
    nxt[1] = cur[1] ^ cur[0];
    nxt[0] = ~cur[0];
  end
endmodule

// File: rtl/phase_reg.sv
module phase_reg
  import step_pattern_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   adv_en,
  input  phase_t nxt,
  output phase_t cur
);
  always_ff @(posedge clk) begin
    if (rst)         cur <= PHASE_HOME;
    else if (adv_en) cur <= nxt;
  end

  AST_RESET_HOME: assert property (@(posedge clk)
    rst |=> cur == PHASE_HOME);                                   // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(cur));                                    // R4
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    adv_en |=> cur == phase_t'($past(cur) + 1'b1));               // R5
endmodule

// File: rtl/phase_decode.sv
module phase_decode
  import step_pattern_pkg::*;
(
  input  phase_t   cur,
  output pattern_t pat
);
  // pat = {w,x,y,z}
  always_comb begin
    pat[3] = cur[1];
    pat[2] = cur[1] & ~cur[0];
    pat[1] = ~cur[1] & cur[0];
    pat[0] = ~cur[1];
  end
endmodule

// File: rtl/step_pattern_gen.sv
module step_pattern_gen
  import step_pattern_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv_en,
  output logic w,
  output logic x,
  output logic y,
  output logic z
);
  phase_t   phase_q;
  phase_t   phase_d;
  pattern_t pat;

  phase_next u_next (.cur(phase_q), .nxt(phase_d));

  phase_reg u_reg (
    .clk(clk), .rst(rst), .adv_en(adv_en), .nxt(phase_d), .cur(phase_q)
  );

  phase_decode u_dec (.cur(phase_q), .pat(pat));

  assign {w, x, y, z} = pat;

  AST_LEGAL_PATTERN: assert property (@(posedge clk) disable iff (rst)
    ({w,x,y,z} == 4'b0001) || ({w,x,y,z} == 4'b0011) ||
    ({w,x,y,z} == 4'b1100) || ({w,x,y,z} == 4'b1000));          // R3
  AST_Z_IS_NOT_W: assert property (@(posedge clk) disable iff (rst)
    z == ~w);                                                     // R3
  AST_RING_A: assert property (@(posedge clk) disable iff (rst)
    adv_en && {w,x,y,z} == 4'b0001 |=> {w,x,y,z} == 4'b0011);    // R2
  AST_RING_B: assert property (@(posedge clk) disable iff (rst)
    adv_en && {w,x,y,z} == 4'b0011 |=> {w,x,y,z} == 4'b1100);    // R2
  AST_RING_C: assert property (@(posedge clk) disable iff (rst)
    adv_en && {w,x,y,z} == 4'b1100 |=> {w,x,y,z} == 4'b1000);    // R2
  AST_RING_D: assert property (@(posedge clk) disable iff (rst)
    adv_en && {w,x,y,z} == 4'b1000 |=> {w,x,y,z} == 4'b0001);    // R2
  AST_RESET_WINS: assert property (@(posedge clk)
    rst && adv_en |=> {w,x,y,z} == 4'b0001);                      // R6
endmodule

// File: tb/step_pattern_gen_bench.sv
`timescale 1ns/1ps
module step_pattern_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv_en = 1'b0;
  logic w, x, y, z;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  step_pattern_gen u_step_pattern_gen (
    .clk(clk), .rst(rst), .adv_en(adv_en), .w(w), .x(x), .y(y), .z(z)
  );

  localparam logic [3:0] RING [4] = '{4'b0001, 4'b0011, 4'b1100, 4'b1000};

  // entry = {rst, adv_en, expected wxyz after the edge}
  localparam int NV = 26;
  localparam logic [5:0] VEC [NV] = '{
    6'b10_0001, 6'b01_0011, 6'b01_1100, 6'b01_1000, 6'b01_0001,
    6'b00_0001, 6'b00_0001, 6'b01_0011, 6'b01_1100, 6'b11_0001,
    6'b01_0011, 6'b01_1100, 6'b00_1100, 6'b01_1000, 6'b10_0001,
    6'b01_0011, 6'b01_1100, 6'b01_1000, 6'b01_0001, 6'b01_0011,
    6'b01_1100, 6'b01_1000, 6'b01_0001, 6'b00_0001, 6'b01_0011,
    6'b01_1100
  };

  task automatic check(input string req, input logic [3:0] got,
                       input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic edge_apply(input logic r, input logic e);
    rst = r; adv_en = e;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int steps;
    // reset state: R1
    edge_apply(1'b1, 1'b0);
    edge_apply(1'b1, 1'b0);
    check("R1", {w,x,y,z}, 4'b0001);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      string req;
      edge_apply(VEC[i][5], VEC[i][4]);
      if (VEC[i][5] && VEC[i][4])  req = "R6";
      else if (VEC[i][5])          req = "R1";
      else if (!VEC[i][4])         req = "R4";
      else                         req = "R2";
      check(req, {w,x,y,z}, VEC[i][3:0]);
      check("R3", {3'b000, z}, {3'b000, ~w});
    end

    // R5: count enabled edges against reference ring, with idle gaps
    edge_apply(1'b1, 1'b0);
    steps = 0;
    for (int k = 0; k < 14; k++) begin
      edge_apply(1'b0, (k % 3) != 2);
      if ((k % 3) != 2) steps++;
      check("R5", {w,x,y,z}, RING[steps % 4]);
    end

    // R6: reset held with enable high stays home
    for (int k = 0; k < 3; k++) begin
      edge_apply(1'b1, 1'b1);
      check("R6", {w,x,y,z}, 4'b0001);
    end
    // R1: holds home after release until an enabled edge
    edge_apply(1'b0, 1'b0);
    check("R1", {w,x,y,z}, 4'b0001);

    // R7: toggling adv_en between edges does not move outputs
    edge_apply(1'b0, 1'b1);
    check("R7", {w,x,y,z}, 4'b0011);
    adv_en = 1'b0; #1;
    check("R7", {w,x,y,z}, 4'b0011);
    adv_en = 1'b1; #1;
    check("R7", {w,x,y,z}, 4'b0011);
    @(posedge clk); #1;
    check("R7", {w,x,y,z}, 4'b1100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule